// File: doc/BRIEF.md
# Cache-Programming Register Pipeline for a Flash Die

This block is a synchronous model of the two page-sized registers that sit between a flash die's byte bus and its memory array during cache programming. A host writes a load command, a column byte, a row byte and then data bytes. The data bytes land in a cache page buffer at a column pointer that steps forward and wraps. A relocate command followed by one column byte moves the pointer within the page that is being loaded.

A cache-confirm command hands the cache page to the data page register and starts an internal program timer. The external busy lasts only a short cache-busy window, so the host can load the next page while the previous one programs. If a program is still running when the next confirm arrives, the handoff waits for it to finish, and the cache-busy window stretches. A final-confirm command keeps the ready/busy line low until its program is done.

A status command switches the byte output to a status byte. That byte holds cache-ready, internal-ready, the previous page's result and the current page's result. A test input can force any chosen row to fail.

Top module: `nand_cache_pipe`

## Requirements
- R1: While reset is high, the block drives `rdy` high and `dout` to 0. After reset, a status command returns 8'h60.
- R2: The load command 8'h80 is followed by a column byte and then a row byte. The column is taken modulo PAGE_BYTES. Each data byte after that is written to the cache at the column pointer, and the pointer then increments modulo PAGE_BYTES. The command 8'h85, given while data is being loaded, is followed by one column byte that resets the pointer.
- R3: Cache-confirm 8'h15 sampled at edge E, with no program running, holds `rdy` low for exactly T_CB cycles: it is high again at the negedge after edge E+T_CB. A page programmed this way never pulls `rdy` low after that window.
- R4: Final-confirm 8'h10 sampled at edge E, with no program running, holds `rdy` low for T_PROG+1 cycles.
- R5: A confirm at edge E while a program is running hands the page over one edge after the program ends. `rdy` is low for the greater of T_CB and (handoff edge - E). Each program lasts T_PROG cycles after its handoff edge.
- R6: The status byte has bit 6 = cache ready and bit 5 = internal ready (1 means ready). Bits 7, 4, 3 and 2 are 0. The command 8'h70 selects the status byte on `dout`, and 8'h80 returns `dout` to data output.
- R7: Status bit 1 takes the result of the previously finished page at each handoff. Bit 0 is 0 while a page programs and takes that page's result when it finishes. A result of 1 means fail.
- R8: A page fails exactly when `fail_en` is high and the page's row byte equals `fail_row`.
- R9: In data mode, `dout` shows the data page register byte at the column pointer. Cache writes do not change the data page register until the next handoff.
- R10: `dout` is registered. It reflects mode and state one edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte (column or row) |
| data_valid | input | 1 | Data byte strobe |
| data_byte | input | 8 | Data byte for the cache page |
| fail_en | input | 1 | Enable forced program failure |
| fail_row | input | 8 | Row that fails when forcing is enabled |
| rdy | output | 1 | Ready/busy, 1 = ready |
| dout | output | 8 | Status byte or data page register byte |

## Verification
The assertions assume that the host issues no confirm while the cache is busy. They also assume that command, address and data strobes never share a cycle, and that every data byte follows a complete address phase. The bench keeps to these rules by driving one strobe per cycle with an idle cycle between strobes. It waits for `rdy` high before each new load, and it lets the stretched handoff happen only through the confirm itself. Busy lengths, poll times and status bytes are computed from the recorded edge numbers of each confirm.

// File: rtl/nandc_pkg.sv
package nandc_pkg;
  localparam logic [7:0] OP_LOAD  = 8'h80;
  localparam logic [7:0] OP_RECOL = 8'h85;
  localparam logic [7:0] OP_CACHE = 8'h15;
  localparam logic [7:0] OP_FINAL = 8'h10;
  localparam logic [7:0] OP_STAT  = 8'h70;
  localparam int ROW_W = 8;

  typedef enum logic [2:0] {
    FS_IDLE, FS_COL, FS_ROW, FS_RECOL, FS_DATA
  } fstate_t;
endpackage

// File: rtl/nandc_front.sv
module nandc_front
  import nandc_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic             addr_valid,
  input  logic [7:0]       addr_byte,
  input  logic             data_valid,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             wr_en_o,
  output logic             confirm_o,
  output logic             final_o,
  output logic             stat_mode_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  fstate_t          st;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             stat_q;
  logic [COL_W-1:0] col_in;

  assign col_in      = COL_W'(addr_byte % 8'(PAGE_BYTES));
  assign wr_en_o     = data_valid && !cmd_valid && !addr_valid && (st == FS_DATA);
  assign confirm_o   = cmd_valid && (cmd_code == OP_CACHE) && (st == FS_DATA);
  assign final_o     = cmd_valid && (cmd_code == OP_FINAL) && (st == FS_DATA);
  assign col_o       = col_q;
  assign row_o       = row_q;
  assign stat_mode_o = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= FS_IDLE;
      col_q  <= '0;
      row_q  <= '0;
      stat_q <= 1'b0;
    end else if (cmd_valid) begin
      case (cmd_code)
        OP_LOAD: begin
          st     <= FS_COL;
          stat_q <= 1'b0;
        end
        OP_RECOL: if (st == FS_DATA) st <= FS_RECOL;
        OP_CACHE, OP_FINAL: if (st == FS_DATA) st <= FS_IDLE;
        OP_STAT: stat_q <= 1'b1;
        default: ;
      endcase
    end else if (addr_valid) begin
      case (st)
        FS_COL: begin
          col_q <= col_in;
          st    <= FS_ROW;
        end
        FS_ROW: begin
          row_q <= addr_byte;
          st    <= FS_DATA;
        end
        FS_RECOL: begin
          col_q <= col_in;
          st    <= FS_DATA;
        end
        default: ;
      endcase
    end else if (wr_en_o) begin
      col_q <= (col_q == LAST_COL) ? '0 : col_q + 1'b1;
    end
  end

  // R2: every accepted data byte moves the column pointer
  a_r2_col_steps: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en_o) |-> (col_q != $past(col_q)))
    else $error("a_r2_col_steps");
endmodule

// File: rtl/nandc_regs.sv
module nandc_regs
  import nandc_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [7:0]       wr_data_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             xfer_i,
  output logic [7:0]       rd_data_o,
  output logic [ROW_W-1:0] drow_o
);
  logic [7:0] cache_mem [PAGE_BYTES];
  logic [7:0] page_mem  [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en_i) cache_mem[col_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (xfer_i) begin
      for (int i = 0; i < PAGE_BYTES; i++) page_mem[i] <= cache_mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drow_o <= '0;
    else if (xfer_i) drow_o <= row_i;
  end

  assign rd_data_o = page_mem[col_i];

  // R9: the data page row only changes on a handoff
  a_r9_row_held: assert property (@(posedge clk) disable iff (rst)
    !xfer_i |=> $stable(drow_o))
    else $error("a_r9_row_held");
endmodule

// File: rtl/nandc_engine.sv
module nandc_engine #(
  parameter int T_CB   = 3,
  parameter int T_PROG = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       confirm_i,
  input  logic       final_i,
  input  logic       fail_i,
  output logic       xfer_o,
  output logic [7:0] status_o,
  output logic       rb_o
);
  localparam int CBW = $clog2(T_CB + 1);
  localparam int PW  = $clog2(T_PROG + 1);

  logic           wait_x, prog_busy, fin_pend, st_prev, st_cur, cache_busy;
  logic [CBW-1:0] cb_cnt;
  logic [PW-1:0]  p_cnt;

  assign cache_busy = wait_x || (cb_cnt != '0);
  assign xfer_o     = wait_x && !prog_busy;
  assign rb_o       = !(cache_busy || fin_pend);
  assign status_o   = {1'b0, !cache_busy, !(prog_busy || wait_x), 3'b000, st_prev, st_cur};

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_x    <= 1'b0;
      prog_busy <= 1'b0;
      fin_pend  <= 1'b0;
      st_prev   <= 1'b0;
      st_cur    <= 1'b0;
      cb_cnt    <= '0;
      p_cnt     <= '0;
    end else begin
      if (xfer_o) begin
        wait_x    <= 1'b0;
        prog_busy <= 1'b1;
        p_cnt     <= PW'(T_PROG);
        st_prev   <= st_cur;
        st_cur    <= 1'b0;
      end else if (prog_busy) begin
        if (p_cnt == PW'(1)) begin
          prog_busy <= 1'b0;
          st_cur    <= fail_i;
          if (!wait_x) fin_pend <= 1'b0;
        end else begin
          p_cnt <= p_cnt - 1'b1;
        end
      end
      if (confirm_i || final_i) begin
        wait_x <= 1'b1;
        cb_cnt <= CBW'(T_CB);
      end else if (cb_cnt != '0) begin
        cb_cnt <= cb_cnt - 1'b1;
      end
      if (final_i) fin_pend <= 1'b1;
    end
  end

  // R3: a confirm is only legal while the cache register is free
  a_r3_confirm_when_free: assert property (@(posedge clk) disable iff (rst)
    (confirm_i || final_i) |-> !cache_busy)
    else $error("a_r3_confirm_when_free");

  // R5: a program only starts from a pending handoff
  a_r5_prog_after_handoff: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_busy) |-> $past(wait_x))
    else $error("a_r5_prog_after_handoff");

  // R4: a final confirm drives the line busy on the next cycle
  a_r4_final_busy: assert property (@(posedge clk) disable iff (rst)
    $past(final_i) |-> !rb_o)
    else $error("a_r4_final_busy");

  // R7: the current-page result reads 0 while that page programs
  a_r7_cur_clear: assert property (@(posedge clk) disable iff (rst)
    prog_busy |-> !st_cur)
    else $error("a_r7_cur_clear");
endmodule

// File: rtl/nand_cache_pipe.sv
module nand_cache_pipe
  import nandc_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int T_CB       = 3,
  parameter int T_PROG     = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       addr_valid,
  input  logic [7:0] addr_byte,
  input  logic       data_valid,
  input  logic [7:0] data_byte,
  input  logic       fail_en,
  input  logic [7:0] fail_row,
  output logic       rdy,
  output logic [7:0] dout
);
  localparam int COL_W = $clog2(PAGE_BYTES);

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row, drow;
  logic             wr_en, confirm, final_cmd, stat_mode, xfer;
  logic [7:0]       status, page_byte;

  nandc_front #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_front (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .data_valid(data_valid),
    .col_o(col), .row_o(row), .wr_en_o(wr_en), .confirm_o(confirm),
    .final_o(final_cmd), .stat_mode_o(stat_mode)
  );

  nandc_regs #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .col_i(col), .wr_data_i(data_byte),
    .row_i(row), .xfer_i(xfer), .rd_data_o(page_byte), .drow_o(drow)
  );

  nandc_engine #(.T_CB(T_CB), .T_PROG(T_PROG)) u_engine (
    .clk(clk), .rst(rst), .confirm_i(confirm), .final_i(final_cmd),
    .fail_i(fail_en && (drow == fail_row)), .xfer_o(xfer),
    .status_o(status), .rb_o(rdy)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= stat_mode ? status : page_byte;
  end
endmodule

// File: tb/sim_nand_cache_pipe.sv
module sim_nand_cache_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int PB  = 8;
  localparam int TCB = 3;
  localparam int TPR = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, addr_valid = 0, data_valid = 0, fail_en = 0;
  logic [7:0] cmd_code = 0, addr_byte = 0, data_byte = 0, fail_row = 0;
  logic rdy;
  logic [7:0] dout;

  int cyc = 0, checks = 0, errors = 0, bcol = 0, dummy;
  logic [7:0] exp_cache [PB];
  logic [7:0] exp_page  [PB];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nand_cache_pipe #(.PAGE_BYTES(PB), .T_CB(TCB), .T_PROG(TPR)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .data_valid(data_valid),
    .data_byte(data_byte), .fail_en(fail_en), .fail_row(fail_row),
    .rdy(rdy), .dout(dout)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c, output int stamp);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(posedge clk); #1 stamp = cyc;
    @(negedge clk); cmd_valid = 0;
    if (c == 8'h15 || c == 8'h10)
      for (int i = 0; i < PB; i++) exp_page[i] = exp_cache[i];
  endtask

  task automatic addr(input logic [7:0] a, input bit is_col);
    @(negedge clk); addr_valid = 1; addr_byte = a;
    @(posedge clk); #1;
    @(negedge clk); addr_valid = 0;
    if (is_col) bcol = a % PB;
  endtask

  task automatic wdata(input logic [7:0] d);
    @(negedge clk); data_valid = 1; data_byte = d;
    @(posedge clk); #1;
    @(negedge clk); data_valid = 0;
    exp_cache[bcol] = d;
    bcol = (bcol + 1) % PB;
  endtask

  task automatic load(input logic [7:0] row, input int col0, input int n, input logic [7:0] base);
    cmd(8'h80, dummy);
    addr(8'(col0), 1'b1);
    addr(row, 1'b0);
    for (int k = 0; k < n; k++) wdata(base + 8'(k));
  endtask

  task automatic wait_rdy(output int t);
    while (!rdy) @(negedge clk);
    t = cyc;
  endtask

  task automatic read_status(output logic [7:0] s);
    cmd(8'h70, dummy);
    @(negedge clk);
    s = dout;
  endtask

  task automatic sweep_page(input string req);
    for (int c = 0; c < PB; c++) begin
      cmd(8'h80, dummy);
      addr(8'(c), 1'b1);
      @(negedge clk);
      chk(req, dout, exp_page[c]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2, tr, s1, s2, tp;
    logic [7:0] s;
    bit rb_ok;
    for (int i = 0; i < PB; i++) begin exp_cache[i] = 0; exp_page[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 rdy in reset", rdy, 1);
    chk("R1 dout in reset", dout, 0);
    @(negedge clk); rst = 0;
    read_status(s);
    chk("R1 R6 status after reset", s, 8'h60);

    // wrap across the page end, then relocate the column
    load(8'd5, 1, PB + 1, 8'hA0);
    cmd(8'h85, dummy);
    addr(8'd2 + 8'(PB), 1'b1);
    wdata(8'h11); wdata(8'h12);
    cmd(8'h10, t0);
    wait_rdy(tr);
    chk("R4 final busy length", tr - t0, TPR + 1);
    read_status(s);
    chk("R6 status after final", s, 8'h60);
    sweep_page("R2 R9 R10 page readback");

    // three-page cache sequence, row 11 forced to fail
    fail_en = 1; fail_row = 8'd11;
    load(8'd10, 0, PB, 8'h30);
    cmd(8'h15, t0);
    wait_rdy(tr);
    chk("R3 cache busy length", tr - t0, TCB);
    read_status(s);
    chk("R6 R7 status first cache", s, 8'h40);

    load(8'd11, 0, 3, 8'h50);
    cmd(8'h15, t1);
    s1 = imax(t1 + 1, t0 + TPR + 2);
    wait_rdy(tr);
    chk("R5 stretched cache busy", tr - t1, imax(TCB, s1 - t1));
    read_status(s);
    chk("R7 status second cache", s, 8'h40);

    load(8'd12, 4, 2, 8'h70);
    cmd(8'h15, t2);
    s2 = imax(t2 + 1, s1 + TPR + 1);
    wait_rdy(tr);
    chk("R5 third cache busy", tr - t2, imax(TCB, s2 - t2));
    read_status(s);
    chk("R7 R8 previous page failed", s, 8'h42);
    rb_ok = 1;
    while (!dout[5] && cyc < s2 + TPR + 50) begin
      if (!rdy) rb_ok = 0;
      @(negedge clk);
    end
    tp = cyc;
    chk("R6 R10 internal ready time", tp, s2 + TPR + 1);
    chk("R3 line stays ready after cache window", rb_ok, 1);
    chk("R6 R7 status after last page", dout, 8'h62);

    // final confirm on the failing row, then with forcing off
    load(8'd11, 0, PB, 8'hC0);
    cmd(8'h10, t0);
    wait_rdy(tr);
    chk("R4 final busy length 2", tr - t0, TPR + 1);
    read_status(s);
    chk("R7 R8 current page fail", s, 8'h61);
    fail_en = 0;
    load(8'd11, 0, PB, 8'hD0);
    cmd(8'h10, t0);
    wait_rdy(tr);
    read_status(s);
    chk("R8 forcing disabled", s, 8'h62);

    // cache writes without confirm leave the data page alone
    load(8'd20, 0, PB, 8'hE0);
    sweep_page("R9 cache isolation");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule